// File: doc/BRIEF.md
# Saturating Adder/Subtractor with Selectable Operand Signedness

This is a purely combinational arithmetic unit. It adds or subtracts two 8-bit operands and clamps the outcome to the range of the selected result type. A 3-bit mode input sets two things: whether each operand is read as two's complement or as a plain magnitude, and whether the result is a signed or an unsigned byte. A single control bit chooses add or subtract.

Alongside the clamped byte, the unit returns a 2-bit status code. The code shows whether the true result was above the representable maximum, below the representable minimum, or in range.

Internally, each operand is first widened. A signed operand takes sign extension and an unsigned operand takes zero extension. Subtraction is carried out as addition of the inverted subtrahend plus one.

In the signed-by-signed mode the saturation decision comes from the top two bits of a one-bit-wider sum. In the mixed modes a two-bit-wider intermediate covers the full range and is compared against the bounds of the result type. The unit is meant to sit in a datapath that needs clamped byte arithmetic without a pipeline stage.

Top module: `sat_addsub`

## Requirements
- R1: In mode 3'b000 both operands and the result are unsigned. An addition whose true value exceeds 255 gives 8'hFF with status 2'b01, and an unsigned addition never reports 2'b10.
- R2: In mode 3'b000 a subtraction whose true value is below 0 gives 8'h00 with status 2'b10.
- R3: In mode 3'b001 both operands and the result are signed. A true value above 127 gives 8'h7F with status 2'b01, and a true value below -128 gives 8'h80 with status 2'b10.
- R4: In mode 3'b001, an addition of operands whose bit 7 differs never saturates: the status is 2'b00 and the result is the exact signed sum.
- R5: In mode 3'b010 operand a is signed, operand b is unsigned (zero-extended, bit 7 is never a sign) and the result is unsigned. A true value below 0 gives 8'h00 with status 2'b10, and one above 255 gives 8'hFF with status 2'b01.
- R6: In mode 3'b011 operand a is signed, operand b is unsigned (zero-extended) and the result is signed. It is clamped to -128 (8'h80, status 2'b10) and +127 (8'h7F, status 2'b01), so b = 8'h80 counts as +128.
- R7: With sub_i = 1 the result equals a minus b under the mode's interpretation, and the same clamping and status rules apply as for addition.
- R8: Whenever the true value fits the result type, the result is that value in the result type's encoding and the status is 2'b00.
- R9: Modes 3'b100 to 3'b111 are invalid and drive a result of 8'h00 and status 2'b00 whatever the operands.
- R10: The status output never takes the value 2'b11. Status 2'b01 always comes with the result type's maximum, and status 2'b10 with its minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand (minuend when subtracting) |
| b_i | input | 8 | Second operand (subtrahend when subtracting) |
| mode_i | input | 3 | Signedness mode: 0 uu->u, 1 ss->s, 2 su->u, 3 su->s, others invalid |
| sub_i | input | 1 | 1 selects subtraction, 0 selects addition |
| res_o | output | 8 | Clamped result |
| stat_o | output | 2 | 2'b00 in range, 2'b01 clamped high, 2'b10 clamped low |

## Verification
Every one of the 65536 operand pairs is applied once. The mode and the add/subtract bit rotate with the operand bits, so each mode meets carries, borrows, same-sign and mixed-sign pairs and operands with bit 7 set. That sweep separates a correct extension rule from a wrong one: a sign-extended unsigned b is caught, because b values above 127 would flip between +128..+255 and negative.

Directed vectors then hit the exact edges that distinguish the clamps. These are 127/128 in the signed modes, 0/255 in the unsigned ones, b = 8'h80 in the mixed signed mode (a legal -128 versus a clamped -129), and invalid modes with operands that would otherwise saturate.

// File: rtl/sat_addsub_pkg.sv
package sat_addsub_pkg;

  typedef enum logic [1:0] {
    ST_OK  = 2'b00,
    ST_OVF = 2'b01,
    ST_UNF = 2'b10
  } stat_e;

  typedef enum logic [2:0] {
    MD_UU_U = 3'd0,
    MD_SS_S = 3'd1,
    MD_SU_U = 3'd2,
    MD_SU_S = 3'd3
  } mode_e;

  typedef struct packed {
    logic valid;
    logic a_sgn;
    logic b_sgn;
    logic r_sgn;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(logic [2:0] m);
    mode_cfg_t c;
    c = '0;
    case (m)
      MD_UU_U: c = '{valid: 1'b1, a_sgn: 1'b0, b_sgn: 1'b0, r_sgn: 1'b0};
      MD_SS_S: c = '{valid: 1'b1, a_sgn: 1'b1, b_sgn: 1'b1, r_sgn: 1'b1};
      MD_SU_U: c = '{valid: 1'b1, a_sgn: 1'b1, b_sgn: 1'b0, r_sgn: 1'b0};
      MD_SU_S: c = '{valid: 1'b1, a_sgn: 1'b1, b_sgn: 1'b0, r_sgn: 1'b1};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sat_opnd_ext.sv
module sat_opnd_ext #(
  parameter int unsigned W  = 8,
  parameter int unsigned XW = W + 2
) (
  input  logic [W-1:0]         d_i,
  input  logic                 sgn_i,
  output logic signed [XW-1:0] q_o
);
  localparam int unsigned PadW = XW - W;

  logic pad_bit;
  assign pad_bit = sgn_i & d_i[W-1];
  assign q_o     = {{PadW{pad_bit}}, d_i};
endmodule

// File: rtl/sat_adder.sv
module sat_adder #(
  parameter int unsigned XW = 10
) (
  input  logic signed [XW-1:0] a_i,
  input  logic signed [XW-1:0] b_i,
  input  logic                 sub_i,
  output logic signed [XW-1:0] sum_o
);
  logic [XW-1:0] b_eff;
  logic [XW-1:0] cin;

  // subtract as a + ~b + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign cin   = {{(XW-1){1'b0}}, sub_i};
  assign sum_o = $signed(a_i + b_eff + cin);
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int unsigned W  = 8,
  parameter int unsigned XW = W + 2
) (
  input  logic signed [XW-1:0] s_i,
  input  logic                 r_sgn_i,
  output logic [W-1:0]         res_o,
  output logic [1:0]           stat_o
);
  import sat_addsub_pkg::*;

  localparam logic signed [XW-1:0] UMax = $signed({{(XW-W){1'b0}}, {W{1'b1}}});
  localparam logic signed [XW-1:0] SMax = $signed({{(XW-W+1){1'b0}}, {(W-1){1'b1}}});
  localparam logic signed [XW-1:0] SMin = ~SMax;
  localparam logic signed [XW-1:0] Zero = '0;

  logic signed [XW-1:0] hi, lo;

  assign hi = r_sgn_i ? SMax : UMax;
  assign lo = r_sgn_i ? SMin : Zero;

  always_comb begin
    if (s_i > hi) begin
      res_o  = hi[W-1:0];
      stat_o = ST_OVF;
    end else if (s_i < lo) begin
      res_o  = lo[W-1:0];
      stat_o = ST_UNF;
    end else begin
      res_o  = s_i[W-1:0];
      stat_o = ST_OK;
    end
  end
endmodule

// File: rtl/sat_ext_msb.sv
module sat_ext_msb #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic [1:0]   stat_o
);
  import sat_addsub_pkg::*;

  logic [W:0] ax, bx, bz, t;
  logic [1:0] code;

  assign ax   = {a_i[W-1], a_i};
  assign bx   = {b_i[W-1], b_i};
  assign bz   = sub_i ? ~bx : bx;
  assign t    = ax + bz + {{W{1'b0}}, sub_i};
  assign code = t[W:W-1];

  always_comb begin
    case (code)
      2'b01: begin
        res_o  = {1'b0, {(W-1){1'b1}}};
        stat_o = ST_OVF;
      end
      2'b10: begin
        res_o  = {1'b1, {(W-1){1'b0}}};
        stat_o = ST_UNF;
      end
      default: begin
        res_o  = t[W-1:0];
        stat_o = ST_OK;
      end
    endcase
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          SS_FAST = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       mode_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic [1:0]       stat_o
);
  import sat_addsub_pkg::*;

  localparam int unsigned XW = WIDTH + 2;

  mode_cfg_t            cfg;
  logic signed [XW-1:0] a_x, b_x, sum;
  logic [WIDTH-1:0]     cl_res, ss_res;
  logic [1:0]           cl_stat, ss_stat;
  logic                 use_ss;

  assign cfg = decode_mode(mode_i);

  sat_opnd_ext #(.W(WIDTH), .XW(XW)) u_ext_a (.d_i(a_i), .sgn_i(cfg.a_sgn), .q_o(a_x));
  sat_opnd_ext #(.W(WIDTH), .XW(XW)) u_ext_b (.d_i(b_i), .sgn_i(cfg.b_sgn), .q_o(b_x));

  sat_adder #(.XW(XW)) u_add (.a_i(a_x), .b_i(b_x), .sub_i(sub_i), .sum_o(sum));

  sat_clamp #(.W(WIDTH), .XW(XW)) u_clamp (
    .s_i(sum), .r_sgn_i(cfg.r_sgn), .res_o(cl_res), .stat_o(cl_stat)
  );

  generate
    if (SS_FAST) begin : g_ss_ext_msb
      sat_ext_msb #(.W(WIDTH)) u_ss (
        .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .res_o(ss_res), .stat_o(ss_stat)
      );
      assign use_ss = (mode_i == MD_SS_S);
    end else begin : g_ss_clamp
      assign ss_res  = cl_res;
      assign ss_stat = cl_stat;
      assign use_ss  = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!cfg.valid) begin
      res_o  = '0;
      stat_o = ST_OK;
    end else if (use_ss) begin
      res_o  = ss_res;
      stat_o = ss_stat;
    end else begin
      res_o  = cl_res;
      stat_o = cl_stat;
    end
  end
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   mode_i,
  input logic         sub_i,
  input logic [W-1:0] res_o,
  input logic [1:0]   stat_o
);
  logic         r_sgn;
  logic [W-1:0] t_max, t_min;

  assign r_sgn = (mode_i == 3'd1) || (mode_i == 3'd3);
  assign t_max = r_sgn ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
  assign t_min = r_sgn ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};

  always_comb begin
    AST_NO_CODE_11: assert (stat_o != 2'b11); // R10
    AST_BAD_MODE_ZERO: assert (!mode_i[2] || (res_o == '0 && stat_o == 2'b00)); // R9
    AST_SAT_HIGH_VALUE: assert (stat_o != 2'b01 || res_o == t_max); // R10
    AST_SAT_LOW_VALUE: assert (stat_o != 2'b10 || res_o == t_min); // R10
    AST_SS_MIXED_SIGN_OK: assert (!(mode_i == 3'd1 && !sub_i && (a_i[W-1] != b_i[W-1])) || stat_o == 2'b00); // R4
    AST_UU_ADD_NO_UNDER: assert (!(mode_i == 3'd0 && !sub_i) || stat_o != 2'b10); // R1
  end
endmodule

bind sat_addsub sat_addsub_chk #(.W(WIDTH)) chk_i (
  .a_i(a_i), .b_i(b_i), .mode_i(mode_i), .sub_i(sub_i), .res_o(res_o), .stat_o(stat_o)
);

// File: tb/sat_addsub_tb_top.sv
`timescale 1ns/1ps
module sat_addsub_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a, b, res;
  logic [2:0] mode;
  logic       sub;
  logic [1:0] stat;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sat_addsub dut_i (
    .a_i(a), .b_i(b), .mode_i(mode), .sub_i(sub), .res_o(res), .stat_o(stat)
  );

  function automatic void ref_model(input logic [7:0] ra, input logic [7:0] rb,
                                    input logic [2:0] rm, input logic rs,
                                    output logic [7:0] er, output logic [1:0] es);
    int av, bv, s, hi, lo;
    bit rsg;
    if (rm > 3'd3) begin
      er = 8'h00; es = 2'b00; return;
    end
    av  = (rm == 3'd0) ? int'(ra) : int'($signed(ra));
    bv  = (rm == 3'd1) ? int'($signed(rb)) : int'(rb);
    s   = rs ? av - bv : av + bv;
    rsg = (rm == 3'd1) || (rm == 3'd3);
    hi  = rsg ? 127 : 255;
    lo  = rsg ? -128 : 0;
    if (s > hi)      begin er = hi[7:0]; es = 2'b01; end
    else if (s < lo) begin er = lo[7:0]; es = 2'b10; end
    else             begin er = s[7:0];  es = 2'b00; end
  endfunction

  function automatic string req_of(input logic [7:0] ra, input logic [7:0] rb,
                                   input logic [2:0] rm, input logic rs, input logic [1:0] es);
    if (rm > 3'd3) return "R9";
    case (rm)
      3'd0: begin
        if (es == 2'b01) return "R1";
        if (es == 2'b10) return "R2";
        return rs ? "R7" : "R8";
      end
      3'd1: begin
        if (es != 2'b00) return "R3";
        if (!rs && ra[7] != rb[7]) return "R4";
        return rs ? "R7" : "R8";
      end
      3'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_vec(input logic [7:0] va, input logic [7:0] vb,
                         input logic [2:0] vm, input logic vs);
    logic [7:0] er;
    logic [1:0] es;
    string tag;
    @(negedge clk);
    a = va; b = vb; mode = vm; sub = vs;
    @(posedge clk);
    #1;
    ref_model(va, vb, vm, vs, er, es);
    tag = req_of(va, vb, vm, vs, es);
    checks++;
    if (res !== er || stat !== es) begin
      fails++;
      $display("FAIL %s a=%h b=%h mode=%0d sub=%0b: got res=%h stat=%b, expected res=%h stat=%b",
               tag, va, vb, vm, vs, res, stat, er, es);
    end
    checks++;
    if (stat === 2'b11) begin
      fails++;
      $display("FAIL R10 status code got %b expected not 11", stat);
    end
  endtask

  task automatic exp_vec(input string tag, input logic [7:0] va, input logic [7:0] vb,
                         input logic [2:0] vm, input logic vs,
                         input logic [7:0] er, input logic [1:0] es);
    @(negedge clk);
    a = va; b = vb; mode = vm; sub = vs;
    @(posedge clk);
    #1;
    checks++;
    if (res !== er || stat !== es) begin
      fails++;
      $display("FAIL %s directed: got res=%h stat=%b, expected res=%h stat=%b",
               tag, res, stat, er, es);
    end
  endtask

  initial begin
    a = '0; b = '0; mode = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    exp_vec("R8", 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 2'b00);
    exp_vec("R1", 8'd200, 8'd100, 3'd0, 1'b0, 8'hFF, 2'b01);
    exp_vec("R2", 8'd5, 8'd10, 3'd0, 1'b1, 8'h00, 2'b10);
    exp_vec("R3", 8'h64, 8'h64, 3'd1, 1'b0, 8'h7F, 2'b01);
    exp_vec("R3", 8'h9C, 8'h9C, 3'd1, 1'b0, 8'h80, 2'b10);
    exp_vec("R3", 8'h80, 8'h01, 3'd1, 1'b1, 8'h80, 2'b10);
    exp_vec("R4", 8'h7F, 8'h80, 3'd1, 1'b0, 8'hFF, 2'b00);
    exp_vec("R7", 8'h05, 8'h03, 3'd1, 1'b1, 8'h02, 2'b00);
    exp_vec("R5", 8'hFF, 8'h05, 3'd2, 1'b0, 8'h04, 2'b00);
    exp_vec("R5", 8'h80, 8'h10, 3'd2, 1'b0, 8'h00, 2'b10);
    exp_vec("R5", 8'h7F, 8'hFF, 3'd2, 1'b0, 8'hFF, 2'b01);
    exp_vec("R6", 8'h00, 8'h80, 3'd3, 1'b0, 8'h7F, 2'b01);
    exp_vec("R6", 8'h00, 8'h80, 3'd3, 1'b1, 8'h80, 2'b00);
    exp_vec("R6", 8'h80, 8'h01, 3'd3, 1'b1, 8'h80, 2'b10);
    exp_vec("R8", 8'h80, 8'h7F, 3'd3, 1'b0, 8'hFF, 2'b00);
    for (int m = 4; m < 8; m++) begin
      exp_vec("R9", 8'h7F, 8'h7F, 3'(m), 1'b0, 8'h00, 2'b00);
      exp_vec("R9", 8'h00, 8'hFF, 3'(m), 1'b1, 8'h00, 2'b00);
    end
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] iv;
      logic [2:0]  k;
      iv = 16'(i);
      k  = iv[2:0] + iv[10:8];
      run_vec(iv[7:0], iv[15:8], {1'b0, k[1:0]}, k[2]);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule